// File: doc/BRIEF.md
# Four-Bank Interleaved Memory Front-End

This block puts one request port in front of four independent storage banks, so that accesses can overlap. The two lowest bits of each word address choose the bank. The rest of the address selects a word inside that bank. Each bank stays occupied for a fixed number of bus cycles per access. While one bank works, a request for another bank can start on the very next cycle. A stream of consecutive addresses therefore runs at one request per cycle. A request for a bank that is still occupied is stalled until that bank can take it.

Requests arrive on a valid/ready channel that carries the address, a write enable and write data. Read results leave on a valid-only channel, in the order the reads were accepted. A small queue of bank numbers tracks which bank owes the next result. Writes are silent: they update the bank at the end of their memory cycle and produce no result.

Each bank is run by a two-state controller:
- States: `B_IDLE` and `B_ACCESS`.
- Launch (`B_IDLE` to `B_ACCESS`): taken on a start.
- Retire (`B_ACCESS` to `B_IDLE`): taken in the final cycle of an access when no new start arrives.
- Relaunch (`B_ACCESS` to `B_ACCESS`): taken in the final cycle when a new start arrives.

The bank performs its read or write in that final cycle.

Top module: `quad_bank_mem`

## Requirements
- R1: The bank is `req_addr[1:0]` and the word inside the bank is `req_addr[ADDR_W-1:2]`. Every one of the 2^ADDR_W addresses holds its own word, and a read returns the last value written to that same address.
- R2: While reset is held and in the first cycle after it, `rsp_valid` is 0 and `req_ready` is 1 for any address.
- R3: A read accepted at clock edge K gives `rsp_valid` high for exactly one cycle, the cycle that follows edge K+CYCLE_LEN, with the read word on `rsp_data`.
- R4: After a bank accepts at edge K, `req_ready` is 0 for requests to that bank until the cycle before edge K+CYCLE_LEN. The next request to that bank is accepted at edge K+CYCLE_LEN at the earliest.
- R5: Requests to banks that are free are accepted on consecutive cycles. A run of sequentially increasing addresses is taken at one request per cycle.
- R6: There is exactly one response per accepted read. Responses leave in the order the reads were accepted.
- R7: An accepted write produces no response.
- R8: A write takes effect at the end of its memory cycle. A read of the same address accepted after it returns the new value.
- R9: A request held with `req_valid` high while `req_ready` is 0 is not lost. It is accepted unchanged once its bank frees, and it has no effect before then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Addressed bank can take the request |
| req_addr | input | ADDR_W | Word address; the low two bits pick the bank |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read result present this cycle |
| rsp_data | output | DATA_W | Read result |

## Verification
The assertions check several behaviours on every cycle:
- A bank starts only when it is ready, and it goes busy right after a start.
- A completion pulse lasts one cycle.
- At most one bank completes a read in any cycle, and that bank is always the one at the head of the order queue.
- The queue never overflows or underflows.

Data integrity needs the bench's directed scenarios, because it depends on stored contents. These scenarios cover the per-address mapping, read-after-write, the exact response cycle, held requests under bank conflicts, and write silence.

// File: rtl/qbm_pkg.sv
`timescale 1ns/1ps
package qbm_pkg;
    localparam int BANKS = 4;
    localparam int SEL_W = 2;

    typedef enum logic {
        B_IDLE   = 1'b0,
        B_ACCESS = 1'b1
    } bank_state_e;
endpackage

// File: rtl/qbm_bank.sv
`timescale 1ns/1ps
module qbm_bank
    import qbm_pkg::*;
#(
    parameter int IDX_W     = 6,
    parameter int DATA_W    = 32,
    parameter int CYCLE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int CNT_W = (CYCLE_LEN > 2) ? $clog2(CYCLE_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CYCLE_LEN - 1);

    bank_state_e       state, state_nxt;
    logic [CNT_W-1:0]  cnt;
    logic              op_we;
    logic [IDX_W-1:0]  op_idx;
    logic [DATA_W-1:0] op_wdata;
    logic [DATA_W-1:0] store [DEPTH];
    logic              final_cyc;

    // Final cycle of the memory cycle: the access is performed here.
    assign final_cyc = (state == B_ACCESS) && (cnt == LAST_CNT);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= B_IDLE;
        else        state <= state_nxt;
    end

    // Next state: launch, relaunch, retire
    always_comb begin
        state_nxt = state;
        unique case (state)
            B_IDLE:   if (start) state_nxt = B_ACCESS;
            B_ACCESS: if (final_cyc) state_nxt = start ? B_ACCESS : B_IDLE;
            default:  state_nxt = B_IDLE;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        ready = 1'b0;
        unique case (state)
            B_IDLE:   ready = 1'b1;
            B_ACCESS: ready = final_cyc;
            default:  ready = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            op_we    <= 1'b0;
            op_idx   <= '0;
            op_wdata <= '0;
        end else if (start) begin
            cnt      <= '0;
            op_we    <= we;
            op_idx   <= idx;
            op_wdata <= wdata;
        end else if (state == B_ACCESS) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (final_cyc && op_we) store[op_idx] <= op_wdata;
    end

    always_ff @(posedge clk) begin
        if (final_cyc && !op_we) rd_data <= store[op_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_done <= 1'b0;
        else        rd_done <= final_cyc && !op_we;
    end

    p_start_when_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ready);
    p_busy_after_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready);
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);
endmodule

// File: rtl/qbm_order_fifo.sv
`timescale 1ns/1ps
module qbm_order_fifo #(
    parameter int ENTRY_W = 2,
    parameter int DEPTH   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [ENTRY_W-1:0] push_data,
    input  logic               pop,
    output logic               empty,
    output logic [ENTRY_W-1:0] head
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [ENTRY_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W-1:0]   count;

    assign empty = (count == '0);
    assign head  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_data;
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count < CNT_W'(DEPTH)));
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/quad_bank_mem.sv
`timescale 1ns/1ps
module quad_bank_mem
    import qbm_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int CYCLE_LEN   = 4,
    parameter int ORDER_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int IDX_W = ADDR_W - SEL_W;

    logic [SEL_W-1:0]  sel;
    logic [IDX_W-1:0]  word_idx;
    logic              accept;
    logic [BANKS-1:0]  bank_ready, bank_start, bank_done;
    logic [DATA_W-1:0] bank_rdata [BANKS];
    logic              ord_empty;
    logic [SEL_W-1:0]  ord_head;

    assign sel       = req_addr[SEL_W-1:0];
    assign word_idx  = req_addr[ADDR_W-1:SEL_W];
    assign req_ready = bank_ready[sel];
    assign accept    = req_valid && req_ready;

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        assign bank_start[g] = accept && (sel == SEL_W'(g));
        qbm_bank #(
            .IDX_W(IDX_W), .DATA_W(DATA_W), .CYCLE_LEN(CYCLE_LEN)
        ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .start(bank_start[g]), .we(req_we), .idx(word_idx), .wdata(req_wdata),
            .ready(bank_ready[g]), .rd_done(bank_done[g]), .rd_data(bank_rdata[g])
        );
    end

    qbm_order_fifo #(.ENTRY_W(SEL_W), .DEPTH(ORDER_DEPTH)) u_order (
        .clk(clk), .rst_n(rst_n),
        .push(accept && !req_we), .push_data(sel),
        .pop(rsp_valid), .empty(ord_empty), .head(ord_head)
    );

    assign rsp_valid = !ord_empty && bank_done[ord_head];
    assign rsp_data  = bank_rdata[ord_head];

    p_one_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_done));
    p_inorder_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_done) |-> (!ord_empty && bank_done[ord_head]));
endmodule

// File: tb/quad_bank_mem_test.sv
`timescale 1ns/1ps
module quad_bank_mem_test;
    localparam int L = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_addr = '0;
    logic        req_we = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    int nchk = 0, nfail = 0, cyc = 0, nrsp = 0;
    logic [31:0] log_data [64];
    int          log_cyc  [64];
    logic [31:0] model    [256];
    bit finished = 0;

    quad_bank_mem #(.ADDR_W(8), .DATA_W(32), .CYCLE_LEN(L), .ORDER_DEPTH(8)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data));

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && rsp_valid && nrsp < 64) begin
            log_data[nrsp] = rsp_data;
            log_cyc[nrsp]  = cyc;
            nrsp++;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int a);
        return {8'hC3, 8'(a), ~8'(a), 8'(a) ^ 8'h3C};
    endfunction

    task automatic issue(input int a, input logic we, input logic [31:0] d, output int acc);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 8'(a); req_we = we; req_wdata = d;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        acc = cyc;
        req_valid = 1'b0;
        if (we) model[a] = d;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        for (int a = 0; a < 4; a++) begin
            req_addr = 8'(a); #0.1;
            chk(req_ready == 1'b1, "R2 ready after reset", req_ready, 1);
        end
        chk(rsp_valid == 1'b0, "R2 no response after reset", rsp_valid, 0);
    endtask

    task automatic t_fill;
        int first, last, acc, n0;
        n0 = nrsp;
        for (int a = 0; a < 256; a++) begin
            issue(a, 1'b1, pat(a), acc);
            if (a == 0) first = acc;
            last = acc;
        end
        chk(last - first == 255, "R5 sequential writes one per cycle", last - first, 255);
        idle(L + 3);
        chk(nrsp == n0, "R7 writes give no response", nrsp - n0, 0);
    endtask

    task automatic t_latency;
        int acc, n0;
        n0 = nrsp;
        issue(5, 1'b0, '0, acc);
        idle(L + 4);
        chk(nrsp == n0 + 1, "R3 single response pulse", nrsp - n0, 1);
        chk(log_cyc[n0] == acc + L, "R3 response cycle", log_cyc[n0], acc + L);
        chk(log_data[n0] == model[5], "R1 read data addr 5", log_data[n0], model[5]);
    endtask

    task automatic t_stream;
        int acc [16];
        int n0;
        n0 = nrsp;
        for (int i = 0; i < 16; i++) issue(16 + i, 1'b0, '0, acc[i]);
        idle(L + 4);
        chk(acc[15] - acc[0] == 15, "R5 read stream one per cycle", acc[15] - acc[0], 15);
        chk(nrsp == n0 + 16, "R6 one response per read", nrsp - n0, 16);
        for (int i = 0; i < 16; i++) begin
            chk(log_cyc[n0 + i] == acc[i] + L, "R3 stream response cycle", log_cyc[n0 + i], acc[i] + L);
            chk(log_data[n0 + i] == model[16 + i], "R6 stream order and data (R1)",
                log_data[n0 + i], model[16 + i]);
        end
    endtask

    task automatic t_conflict;
        int acc0, acc1, acc2, acc3, n0;
        n0 = nrsp;
        issue(8, 1'b0, '0, acc0);
        // same bank 0 request held while busy
        @(negedge clk);
        req_valid = 1'b1; req_addr = 8'd12; req_we = 1'b0; #1;
        chk(req_ready == 1'b0, "R4 busy bank not ready", req_ready, 0);
        req_valid = 1'b0;
        issue(12, 1'b0, '0, acc1);
        chk(acc1 - acc0 == L, "R4 R9 held read accepted when bank frees", acc1 - acc0, L);
        issue(44, 1'b1, 32'hDEAD_0044, acc2);
        chk(acc2 - acc1 == L, "R9 held write accepted when bank frees", acc2 - acc1, L);
        issue(44, 1'b0, '0, acc3);
        idle(L + 4);
        chk(nrsp == n0 + 3, "R6 three responses", nrsp - n0, 3);
        chk(log_data[n0] == model[8], "R6 first response addr 8", log_data[n0], model[8]);
        chk(log_data[n0 + 1] == model[12], "R1 second response addr 12", log_data[n0 + 1], model[12]);
        chk(log_data[n0 + 2] == 32'hDEAD_0044, "R9 held write stored", log_data[n0 + 2], 32'hDEAD_0044);
    endtask

    task automatic t_raw;
        int aw, ar, ao, n0;
        n0 = nrsp;
        issue(33, 1'b1, 32'h1234_5678, aw);
        issue(33, 1'b0, '0, ar);
        issue(34, 1'b0, '0, ao);
        idle(L + 4);
        chk(nrsp == n0 + 2, "R7 R8 two responses", nrsp - n0, 2);
        chk(log_data[n0] == 32'h1234_5678, "R8 read after write", log_data[n0], 32'h1234_5678);
        chk(log_data[n0 + 1] == model[34], "R1 neighbour unchanged", log_data[n0 + 1], model[34]);
    endtask

    task automatic t_mixed;
        int acc, n0;
        int ord [4] = '{3, 2, 1, 0};
        n0 = nrsp;
        issue(40, 1'b1, 32'hA0A0_0040, acc);
        issue(3, 1'b0, '0, acc);
        issue(41, 1'b1, 32'hB1B1_0041, acc);
        issue(2, 1'b0, '0, acc);
        issue(1, 1'b0, '0, acc);
        issue(0, 1'b0, '0, acc);
        issue(40, 1'b0, '0, acc);
        idle(L + 4);
        chk(nrsp == n0 + 5, "R6 R7 mixed response count", nrsp - n0, 5);
        for (int i = 0; i < 4; i++)
            chk(log_data[n0 + i] == model[ord[i]], "R6 mixed order", log_data[n0 + i], model[ord[i]]);
        chk(log_data[n0 + 4] == 32'hA0A0_0040, "R8 mixed write visible", log_data[n0 + 4], 32'hA0A0_0040);
    endtask

    always @(posedge clk) begin
        if (!finished && cyc > 20000) begin
            finished = 1;
            nchk++; nfail++;
            $display("FAIL watchdog: actual %0d expected < 20000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #0.5; chk(rsp_valid == 1'b0, "R2 no response in reset", rsp_valid, 0);
        rst_n = 1'b1;
        t_reset;
        t_fill;
        t_latency;
        t_stream;
        t_conflict;
        t_raw;
        t_mixed;
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule